// File: doc/BRIEF.md
# V.110 Frame Alignment Receiver

This block takes a bit-serial B-channel stream, one bit per `bit_valid_i` strobe, and finds the boundaries of V.110 80-bit frames. A frame has ten octets. The first octet is all zeros. Each of the other nine octets starts with a one, and seven payload bits follow it. While hunting, the receiver looks for a run of at least eight zeros that ends in a one. It takes that one as the first bit of the first data octet and counts octets from there.

Once locked, the receiver puts out the nine data-bearing octets of every frame as bytes and drops the zero octet. Each byte keeps its leading one in the MSB, and `sof_o` marks the first byte of each frame. If a data octet has no leading one, or the zero octet holds a one, the receiver pulses `frame_err_o`, drops `locked_o` and goes back to hunting. Decoding of the V.110 status and data bits, rate adaptation and buffering are done downstream.

Top module: `v110_frame_rx`

## Requirements
- R1: While `rst_ni` is low, `locked_o`, `byte_valid_o`, `sof_o`, `frame_err_o` and `byte_o` are all 0.
- R2: While hunting, a valid one bit that follows at least eight consecutive valid zeros sets `locked_o` on the next clock. The zero run is counted over every valid bit, including bits received while locked or on an error bit.
- R3: A one that follows fewer than eight consecutive zeros does not cause lock.
- R4: While locked, exactly nine bytes are put out per 80-bit frame, and the all-zero first octet gives no byte.
- R5: Each output byte is `{leading one, seven payload bits in arrival order}`, so bit 7 is the first-arriving bit of the octet. `byte_valid_o` is high for exactly one clock, the clock after the octet's eighth bit.
- R6: `sof_o` is high together with `byte_valid_o` on the first of the nine bytes and at no other time.
- R7: While locked, a data octet (octets 2 to 10) whose first bit is 0 causes a one-clock `frame_err_o` pulse on the next clock, and `locked_o` drops on that same clock.
- R8: While locked, a one in any bit of the zero octet causes a one-clock `frame_err_o` pulse and loss of lock.
- R9: A clock with `bit_valid_i` low has no effect: the value on `bit_i` is ignored, no pulse is produced and `locked_o` holds.
- R10: After a frame error the receiver hunts again and locks on the next zeros-then-one pattern, then delivers correct frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Strobe that marks `bit_i` as a new line bit |
| bit_i | input | 1 | Serial B-channel data bit |
| byte_o | output | 8 | Recovered octet, leading one in the MSB |
| byte_valid_o | output | 1 | One-clock pulse when `byte_o` holds a new octet |
| sof_o | output | 1 | Marks the first octet of a frame |
| locked_o | output | 1 | Frame alignment held |
| frame_err_o | output | 1 | One-clock pulse on loss of alignment |

## Verification
The hardest case to reach is the recovery path. After a bad octet, the rest of the broken frame can hold long zero runs inside the payload, and the receiver may lock on a false boundary for a short time before the true zero octet pulls it back. The stimulus first sends clean frames. It then sends frames with a missing leading one or a stray one in the zero octet, followed by clean frames, so that both error paths and the relock are exercised. A long stream of bits biased toward zero, sent with irregular valid gaps, then drives many false locks. A bit-level reference model in the bench follows every cycle of this.

// File: rtl/v110_rx_pkg.sv
package v110_rx_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } rx_state_e;
endpackage

// File: rtl/v110_zero_run.sv
// Saturating count of consecutive valid zeros
module v110_zero_run #(
  parameter int unsigned RUN_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic run_full_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (bit_valid_i) begin
      if (bit_i) cnt_q <= '0;
      else if (cnt_q != CW'(RUN_LEN)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_full_o = (cnt_q == CW'(RUN_LEN));
endmodule

// File: rtl/v110_frame_pos.sv
// Bit and octet position inside the frame
module v110_frame_pos #(
  parameter int unsigned OCT_W        = 8,
  parameter int unsigned FRAME_OCTETS = 10,
  localparam int unsigned BW = $clog2(OCT_W),
  localparam int unsigned OW = $clog2(FRAME_OCTETS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  output logic [BW-1:0] bit_idx_o,
  output logic [OW-1:0] oct_idx_o
);
  logic [BW-1:0] bit_q;
  logic [OW-1:0] oct_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      oct_q <= '0;
    end else if (load_i) begin
      // acquiring bit is bit 0 of octet 1
      bit_q <= BW'(1);
      oct_q <= OW'(1);
    end else if (step_i) begin
      if (bit_q == BW'(OCT_W - 1)) begin
        bit_q <= '0;
        oct_q <= (oct_q == OW'(FRAME_OCTETS - 1)) ? '0 : oct_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign bit_idx_o = bit_q;
  assign oct_idx_o = oct_q;
endmodule

// File: rtl/v110_octet_asm.sv
// Holds the last OCT_W-1 valid bits; the octet is completed by the current bit
module v110_octet_asm #(
  parameter int unsigned OCT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [OCT_W-1:0] octet_o
);
  logic [OCT_W-2:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[OCT_W-3:0], bit_i};
  end

  assign octet_o = {hist_q, bit_i};
endmodule

// File: rtl/v110_frame_rx.sv
module v110_frame_rx
  import v110_rx_pkg::*;
#(
  parameter int unsigned OCT_W        = 8,
  parameter int unsigned FRAME_OCTETS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic [OCT_W-1:0] byte_o,
  output logic             byte_valid_o,
  output logic             sof_o,
  output logic             locked_o,
  output logic             frame_err_o
);
  localparam int unsigned BW = $clog2(OCT_W);
  localparam int unsigned OW = $clog2(FRAME_OCTETS);

  rx_state_e        state_q;
  logic             run_full;
  logic [BW-1:0]    bit_idx;
  logic [OW-1:0]    oct_idx;
  logic [OCT_W-1:0] octet;
  logic             acq, step, err, done;

  v110_zero_run #(.RUN_LEN(OCT_W)) u_zero_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_valid_i(bit_valid_i),
    .bit_i      (bit_i),
    .run_full_o (run_full)
  );

  v110_frame_pos #(.OCT_W(OCT_W), .FRAME_OCTETS(FRAME_OCTETS)) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (acq),
    .step_i   (step),
    .bit_idx_o(bit_idx),
    .oct_idx_o(oct_idx)
  );

  v110_octet_asm #(.OCT_W(OCT_W)) u_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(bit_valid_i),
    .bit_i  (bit_i),
    .octet_o(octet)
  );

  always_comb begin
    acq  = 1'b0;
    step = 1'b0;
    err  = 1'b0;
    done = 1'b0;
    if (bit_valid_i) begin
      if (state_q == ST_HUNT) begin
        acq = bit_i & run_full;
      end else if (oct_idx == '0) begin
        // alignment octet must stay all zero
        if (bit_i) err = 1'b1;
        else       step = 1'b1;
      end else if ((bit_idx == '0) && !bit_i) begin
        err = 1'b1;
      end else begin
        step = 1'b1;
        done = (bit_idx == BW'(OCT_W - 1));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_HUNT;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      sof_o        <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      if (acq)      state_q <= ST_LOCK;
      else if (err) state_q <= ST_HUNT;
      byte_valid_o <= done;
      sof_o        <= done && (oct_idx == OW'(1));
      frame_err_o  <= err;
      if (done) byte_o <= octet;
    end
  end

  assign locked_o = (state_q == ST_LOCK);
endmodule

// File: rtl/v110_frame_rx_chk.sv
module v110_frame_rx_chk #(
  parameter int unsigned OCT_W        = 8,
  parameter int unsigned FRAME_OCTETS = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_valid_i,
  input logic             bit_i,
  input logic [OCT_W-1:0] byte_o,
  input logic             byte_valid_o,
  input logic             sof_o,
  input logic             locked_o,
  input logic             frame_err_o
);
  localparam int DATA_OCTETS = FRAME_OCTETS - 1;

  int unsigned bytes_in_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bytes_in_frame <= 0;
    else if (frame_err_o || !locked_o) bytes_in_frame <= 0;
    else if (byte_valid_o && sof_o) bytes_in_frame <= 1;
    else if (byte_valid_o) bytes_in_frame <= bytes_in_frame + 1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!locked_o && !byte_valid_o && !sof_o && !frame_err_o && byte_o == '0)
        else $error("outputs active in reset");
    end
  end

  assert_lock_on_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(bit_valid_i && bit_i));

  assert_byte_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> locked_o);

  assert_nine_bytes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !sof_o) |-> (bytes_in_frame > 0 && bytes_in_frame < DATA_OCTETS));

  assert_msb_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> byte_o[OCT_W-1]);

  assert_pulse_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_valid_o, frame_err_o}));

  assert_sof_with_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> byte_valid_o);

  assert_err_unlocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> (!locked_o && $past(locked_o)));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> (!byte_valid_o && !frame_err_o && $stable(locked_o)));
endmodule

bind v110_frame_rx v110_frame_rx_chk #(.OCT_W(OCT_W), .FRAME_OCTETS(FRAME_OCTETS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_valid_i (bit_valid_i),
  .bit_i       (bit_i),
  .byte_o      (byte_o),
  .byte_valid_o(byte_valid_o),
  .sof_o       (sof_o),
  .locked_o    (locked_o),
  .frame_err_o (frame_err_o)
);

// File: tb/tb_v110_frame_rx.sv
`timescale 1ns/1ps
module tb_v110_frame_rx;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic [7:0] byte_o;
  logic byte_valid_o, sof_o, locked_o, frame_err_o;

  always #2 clk = ~clk;

  v110_frame_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_valid_i(bit_valid), .bit_i(bit_in),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .sof_o(sof_o),
    .locked_o(locked_o), .frame_err_o(frame_err_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  int m_zrun = 0, m_oct = 0, m_pos = 0, m_acc = 0, exp_byte = 0;
  bit m_locked = 0;
  int bytes_seen = 0, sof_seen = 0, err_seen = 0, sof_byte = 0;
  int unsigned lfsr = 32'h1ace_b00c;

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // starts and ends at a negedge
  task automatic step(bit v, bit b);
    bit e_bv, e_sof, e_err;
    int exp_all, act_all;
    e_bv = 0; e_sof = 0; e_err = 0;
    bit_valid = v;
    bit_in = b;
    if (v) begin
      if (!m_locked) begin
        if (b && m_zrun >= 8) begin
          m_locked = 1; m_oct = 1; m_pos = 1; m_acc = 1;
        end
      end else if (m_oct == 0) begin
        if (b) e_err = 1;
        else begin
          m_pos++;
          if (m_pos == 8) begin m_pos = 0; m_oct = 1; end
        end
      end else if (m_pos == 0 && !b) begin
        e_err = 1;
      end else begin
        m_acc = (m_pos == 0) ? int'(b) : (((m_acc << 1) | int'(b)) & 255);
        m_pos++;
        if (m_pos == 8) begin
          e_bv = 1;
          e_sof = (m_oct == 1);
          exp_byte = m_acc;
          m_pos = 0;
          m_oct = (m_oct == 9) ? 0 : m_oct + 1;
        end
      end
      if (e_err) m_locked = 0;
      m_zrun = b ? 0 : ((m_zrun < 8) ? m_zrun + 1 : 8);
    end
    @(posedge clk);
    @(negedge clk);
    exp_all = (exp_byte << 4) | (int'(e_bv) << 3) | (int'(e_sof) << 2) | (int'(m_locked) << 1) | int'(e_err);
    act_all = int'({byte_o, byte_valid_o, sof_o, locked_o, frame_err_o});
    check(cur_req, "{byte,valid,sof,lock,err}", act_all, exp_all);
    if (byte_valid_o) bytes_seen++;
    if (sof_o) begin sof_seen++; sof_byte = int'(byte_o); end
    if (frame_err_o) err_seen++;
  endtask

  function automatic bit next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  task automatic send_octet(logic [7:0] o, bit gap);
    for (int i = 7; i >= 0; i--) begin
      step(1'b1, o[i]);
      if (gap) step(1'b0, next_rand());
    end
  endtask

  function automatic logic [6:0] pay(int seed, int k);
    return 7'((seed * 37 + k * 11) & 127);
  endfunction

  // bad: 0 clean, 1..9 data octet lacks leading one, 10 stray one in zero octet
  task automatic send_frame(int seed, int bad, bit gap);
    send_octet((bad == 10) ? 8'h10 : 8'h00, gap);
    for (int k = 1; k <= 9; k++)
      send_octet({(bad == k) ? 1'b0 : 1'b1, pay(seed, k)}, gap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", "reset outputs", int'({byte_o, byte_valid_o, sof_o, locked_o, frame_err_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    cur_req = "R9";
    for (int i = 0; i < 12; i++) step(1'b0, i[0]);
    check("R9", "locked after idle ones", int'(locked_o), 0);

    cur_req = "R3";
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    send_octet(8'hA5, 1'b0);
    check("R3", "locked after short zero run", int'(locked_o), 0);

    cur_req = "R2";
    bytes_seen = 0; sof_seen = 0;
    send_frame(1, 0, 1'b0);
    check("R2", "locked after alignment", int'(locked_o), 1);
    check("R5", "first byte of frame", sof_byte, int'({1'b1, pay(1, 1)}));
    cur_req = "R4";
    send_frame(2, 0, 1'b0);
    send_frame(3, 0, 1'b0);
    check("R4", "bytes in three frames", bytes_seen, 27);
    check("R6", "sof count in three frames", sof_seen, 3);

    cur_req = "R9";
    bytes_seen = 0;
    send_frame(4, 0, 1'b1);
    check("R9", "bytes with valid gaps", bytes_seen, 9);

    cur_req = "R7";
    e0 = err_seen;
    send_frame(5, 5, 1'b0);
    check("R7", "error on missing leading one", int'(err_seen > e0), 1);

    cur_req = "R10";
    send_frame(6, 0, 1'b0);
    bytes_seen = 0;
    send_frame(7, 0, 1'b0);
    check("R10", "bytes after relock", bytes_seen, 9);
    check("R10", "locked after relock", int'(locked_o), 1);

    cur_req = "R8";
    e0 = err_seen;
    send_frame(8, 10, 1'b0);
    check("R8", "error on one in zero octet", int'(err_seen > e0), 1);
    send_frame(9, 0, 1'b0);
    bytes_seen = 0;
    send_frame(10, 0, 1'b0);
    check("R10", "bytes after zero-octet error", bytes_seen, 9);

    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      bit v, b;
      v = next_rand() | next_rand();
      b = next_rand() & next_rand();
      step(v, b);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule